// File: doc/BRIEF.md
# Two-Level Stacked Interrupt Status Controller

This block gathers interrupt events from two sources, a bus-side group and a DMA-side group, into host-readable status registers. Each group has a visible status level and a hidden second level. While a group's visible level holds an interrupt the host has not yet serviced, any new events for that group are collected in the hidden level. The visible value does not change during that time. The active-low request pin `irq_n` is driven low whenever either group has an interrupt pending.

The host services a group by pulsing that group's read strobe. The strobe clears the visible level. The request pin is then forced high for a fixed gap of `GAP_CYCLES` clocks. At the end of the gap the hidden contents move up into view, and the pin drops again if any promoted event is able to interrupt.

Each event bit has an enable bit and a fatal-class bit. A disabled nonfatal event is recorded in the status but never interrupts. A fatal event interrupts regardless of its enable bit. While the DMA data FIFO is not empty after a DMA-side interrupt, bus-side events are held back, and they are posted once the FIFO reports empty.

Top module: `irq_stack_ctrl`

## Requirements
- R1: After reset both status outputs read zero and `irq_n` is high.
- R2: An event bit whose enable bit is 1 sets the matching status bit and drives `irq_n` low at the first clock edge after it is presented. Status bit i corresponds to event bit i.
- R3: While a group has a pending interrupt, new events of that group leave its visible status unchanged.
- R4: Events that arrive while a group is pending are OR-accumulated in the hidden level. A read strobe followed by the gap reveals all of them together.
- R5: A read strobe clears the visible status of its group at the next edge. `irq_n` then stays high for exactly `GAP_CYCLES` (default 3) cycles. After that the hidden level becomes visible, and `irq_n` goes low if it holds an interrupting event.
- R6: An event whose enable bit is 0 and whose fatal bit is 0 sets its status bit but neither sets the pending flag nor lowers `irq_n`.
- R7: After a disabled nonfatal event, a later event goes straight into the visible status and is not stacked. The earlier bit stays set beside it.
- R8: Events presented in the same cycle merge into the visible level, both within one group and across both groups.
- R9: An event whose fatal bit is 1 sets the pending flag and lowers `irq_n` even when its enable bit is 0.
- R10: Once an interrupting DMA event has been posted while `dma_fifo_empty` is 0, bus-side events are held. They are posted to the bus status two edges after `dma_fifo_empty` is sampled high.
- R11: `irq_n` is low exactly when either group is pending and no read gap is running. During a gap it stays high even if the other group is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ev | input | BUS_W | Bus-side event pulses, one bit per cause |
| bus_en | input | BUS_W | Bus-side enable bits (1 = may interrupt) |
| bus_fatal | input | BUS_W | Bus-side fatal-class bits (1 = ignores enable) |
| bus_rd | input | 1 | Read-and-clear strobe for bus-side status |
| bus_stat | output | BUS_W | Visible bus-side status |
| dma_ev | input | DMA_W | DMA-side event pulses |
| dma_en | input | DMA_W | DMA-side enable bits |
| dma_fatal | input | DMA_W | DMA-side fatal-class bits |
| dma_rd | input | 1 | Read-and-clear strobe for DMA-side status |
| dma_stat | output | DMA_W | Visible DMA-side status |
| dma_fifo_empty | input | 1 | High when the DMA data FIFO holds no data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A wrong state in a group's stacking logic shows up at the status port one edge after the event or strobe. It appears as a visible value that changes while the group is pending, as events missing after promotion, or as a disabled event that pulls `irq_n` low. A wrong gap count appears at the first edge where `irq_n` would fall, either one cycle early or one cycle late against the three-cycle window. A broken hold-off on the bus side appears as bus status bits that show up while the FIFO is still reporting data, or that never show up after it drains.

// File: rtl/irq_stack_pkg.sv
package irq_stack_pkg;

    // Per-group first-level state
    typedef enum logic [1:0] {
        LVL_OPEN = 2'd0,   // nothing pending: events land in the visible level
        LVL_PEND = 2'd1,   // interrupt pending: events go to the hidden level
        LVL_WAIT = 2'd2    // cleared by host, waiting for the gap to promote
    } lvl_state_e;

    // Smallest allowed deassertion gap after a read
    localparam int unsigned MIN_GAP = 3;

    // Width of a down-counter that can hold value n
    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/irq_gap_timer.sv
module irq_gap_timer
    import irq_stack_pkg::*;
#(
    parameter int unsigned GAP_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic promote
);
    localparam int unsigned GAP = (GAP_CYCLES < MIN_GAP) ? MIN_GAP : GAP_CYCLES;
    localparam int unsigned CW  = cnt_bits(GAP);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(GAP);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy    = (cnt_q != '0);
    assign promote = (cnt_q == CW'(1)) && !start;

    // R5: the gap never ends early: a running gap that is not restarted counts down by one
    assert_gap_count_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && !start) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/irq_hold_gate.sv
module irq_hold_gate #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] ev_in,
    input  logic         dma_irq_evt,
    input  logic         fifo_empty,
    output logic [W-1:0] ev_out,
    output logic         locked
);
    logic         lock_q;
    logic [W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
            held_q <= '0;
        end else begin
            if (fifo_empty)       lock_q <= 1'b0;
            else if (dma_irq_evt) lock_q <= 1'b1;
            held_q <= lock_q ? (held_q | ev_in) : '0;
        end
    end

    assign locked = lock_q;
    assign ev_out = lock_q ? '0 : (ev_in | held_q);

    // R10: the hold-off persists until the FIFO reports empty
    assert_lock_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (lock_q && !fifo_empty) |=> lock_q);
    // R10: an empty FIFO releases the hold-off at the next edge
    assert_lock_release_R10: assert property (@(posedge clk) disable iff (rst)
        fifo_empty |=> !lock_q);

endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
    import irq_stack_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] ev,
    input  logic [W-1:0] en,
    input  logic [W-1:0] fatal,
    input  logic         rd_clr,
    input  logic         promote,
    output logic [W-1:0] stat,
    output logic         pend,
    output logic         irq_evt
);
    lvl_state_e   st_q, st_d;
    logic [W-1:0] vis_q, vis_d;
    logic [W-1:0] stk_q, stk_d;
    logic         stk_arm_q, stk_arm_d;
    logic [W-1:0] arm_bits;

    assign arm_bits = ev & (fatal | en);
    assign irq_evt  = |arm_bits;

    always_comb begin
        st_d      = st_q;
        vis_d     = vis_q;
        stk_d     = stk_q;
        stk_arm_d = stk_arm_q;
        if (rd_clr) begin
            vis_d     = '0;
            st_d      = LVL_WAIT;
            stk_d     = stk_q | ev;
            stk_arm_d = stk_arm_q | irq_evt;
        end else begin
            unique case (st_q)
                LVL_OPEN: begin
                    vis_d = vis_q | ev;
                    if (irq_evt) st_d = LVL_PEND;
                end
                LVL_PEND: begin
                    stk_d     = stk_q | ev;
                    stk_arm_d = stk_arm_q | irq_evt;
                end
                LVL_WAIT: begin
                    if (promote) begin
                        vis_d     = stk_q | ev;
                        stk_d     = '0;
                        stk_arm_d = 1'b0;
                        st_d      = (stk_arm_q || irq_evt) ? LVL_PEND : LVL_OPEN;
                    end else begin
                        stk_d     = stk_q | ev;
                        stk_arm_d = stk_arm_q | irq_evt;
                    end
                end
                default: st_d = LVL_OPEN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= LVL_OPEN;
            vis_q     <= '0;
            stk_q     <= '0;
            stk_arm_q <= 1'b0;
        end else begin
            st_q      <= st_d;
            vis_q     <= vis_d;
            stk_q     <= stk_d;
            stk_arm_q <= stk_arm_d;
        end
    end

    assign stat = vis_q;
    assign pend = (st_q == LVL_PEND);

    // R3: visible level frozen while pending and not read
    assert_hide_R3: assert property (@(posedge clk) disable iff (rst)
        (pend && !rd_clr) |=> $stable(stat));
    // R5: a read clears the visible level and the pending flag
    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        rd_clr |=> (stat == '0 && !pend));
    // R6: disabled nonfatal events post status without pending
    assert_masked_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q == LVL_OPEN && !rd_clr && !irq_evt && ev != '0)
        |=> (!pend && ((stat & $past(ev)) == $past(ev))));
    // R9: fatal events always arm the pending flag
    assert_fatal_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q == LVL_OPEN && !rd_clr && (ev & fatal) != '0) |=> pend);

endmodule

// File: rtl/irq_stack_ctrl.sv
module irq_stack_ctrl
    import irq_stack_pkg::*;
#(
    parameter int unsigned BUS_W      = 16,
    parameter int unsigned DMA_W      = 8,
    parameter int unsigned GAP_CYCLES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] bus_ev,
    input  logic [BUS_W-1:0] bus_en,
    input  logic [BUS_W-1:0] bus_fatal,
    input  logic             bus_rd,
    output logic [BUS_W-1:0] bus_stat,
    input  logic [DMA_W-1:0] dma_ev,
    input  logic [DMA_W-1:0] dma_en,
    input  logic [DMA_W-1:0] dma_fatal,
    input  logic             dma_rd,
    output logic [DMA_W-1:0] dma_stat,
    input  logic             dma_fifo_empty,
    output logic             irq_n
);
    logic [BUS_W-1:0] bus_ev_q;
    logic             bus_locked;
    logic             bus_pend, dma_pend;
    logic             bus_irq_evt, dma_irq_evt;
    logic             gap_busy, gap_promote;

    irq_hold_gate #(.W(BUS_W)) u_hold (
        .clk         (clk),
        .rst         (rst),
        .ev_in       (bus_ev),
        .dma_irq_evt (dma_irq_evt),
        .fifo_empty  (dma_fifo_empty),
        .ev_out      (bus_ev_q),
        .locked      (bus_locked)
    );

    irq_level_stack #(.W(BUS_W)) u_bus_lvl (
        .clk     (clk),
        .rst     (rst),
        .ev      (bus_ev_q),
        .en      (bus_en),
        .fatal   (bus_fatal),
        .rd_clr  (bus_rd),
        .promote (gap_promote),
        .stat    (bus_stat),
        .pend    (bus_pend),
        .irq_evt (bus_irq_evt)
    );

    irq_level_stack #(.W(DMA_W)) u_dma_lvl (
        .clk     (clk),
        .rst     (rst),
        .ev      (dma_ev),
        .en      (dma_en),
        .fatal   (dma_fatal),
        .rd_clr  (dma_rd),
        .promote (gap_promote),
        .stat    (dma_stat),
        .pend    (dma_pend),
        .irq_evt (dma_irq_evt)
    );

    irq_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .start   (bus_rd || dma_rd),
        .busy    (gap_busy),
        .promote (gap_promote)
    );

    assign irq_n = !((bus_pend || dma_pend) && !gap_busy);

    // R5: the pin is released right after any read strobe
    assert_rd_release_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd || dma_rd) |=> irq_n);
    // R10: a held bus event never reaches the bus status while locked
    assert_lock_block_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_locked && !bus_rd && !u_bus_lvl.pend && u_bus_lvl.st_q == LVL_OPEN) |=> $stable(bus_stat));

endmodule

// File: tb/test_irq_stack_ctrl.sv
module test_irq_stack_ctrl;
    localparam int BUS_W = 16;
    localparam int DMA_W = 8;

    logic             clk = 1'b0;
    logic             rst;
    logic [BUS_W-1:0] bus_ev, bus_en, bus_fatal;
    logic             bus_rd;
    logic [BUS_W-1:0] bus_stat;
    logic [DMA_W-1:0] dma_ev, dma_en, dma_fatal;
    logic             dma_rd;
    logic [DMA_W-1:0] dma_stat;
    logic             dma_fifo_empty;
    logic             irq_n;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    irq_stack_ctrl #(.BUS_W(BUS_W), .DMA_W(DMA_W), .GAP_CYCLES(3)) i_irq_stack_ctrl (
        .clk(clk), .rst(rst),
        .bus_ev(bus_ev), .bus_en(bus_en), .bus_fatal(bus_fatal),
        .bus_rd(bus_rd), .bus_stat(bus_stat),
        .dma_ev(dma_ev), .dma_en(dma_en), .dma_fatal(dma_fatal),
        .dma_rd(dma_rd), .dma_stat(dma_stat),
        .dma_fifo_empty(dma_fifo_empty), .irq_n(irq_n)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        bus_ev = '0; bus_en = '1; bus_fatal = '0; bus_rd = 1'b0;
        dma_ev = '0; dma_en = '1; dma_fatal = '0; dma_rd = 1'b0;
        dma_fifo_empty = 1'b1;
        tick(); tick();
        rst = 1'b0;
        tick();
    endtask

    task automatic fire_bus(input logic [BUS_W-1:0] v);
        bus_ev = v; tick(); bus_ev = '0;
    endtask

    task automatic fire_dma(input logic [DMA_W-1:0] v);
        dma_ev = v; tick(); dma_ev = '0;
    endtask

    task automatic test_reset();
        do_reset();
        check("R1 bus_stat", 32'(bus_stat), 32'h0);
        check("R1 dma_stat", 32'(dma_stat), 32'h0);
        check("R1 irq_n", 32'(irq_n), 32'h1);
    endtask

    task automatic test_basic();
        do_reset();
        fire_bus(16'h0001);
        check("R2 bus_stat", 32'(bus_stat), 32'h0001);
        check("R2 irq_n", 32'(irq_n), 32'h0);
        do_reset();
        fire_dma(8'h04);
        check("R2 dma_stat", 32'(dma_stat), 32'h04);
        check("R11 irq_n dma pend", 32'(irq_n), 32'h0);
    endtask

    task automatic test_stack();
        do_reset();
        fire_bus(16'h0001);
        fire_bus(16'h0004);
        check("R3 bus_stat held", 32'(bus_stat), 32'h0001);
        fire_bus(16'h0020);
        check("R3 bus_stat still held", 32'(bus_stat), 32'h0001);
        bus_rd = 1'b1; tick(); bus_rd = 1'b0;
        check("R5 cleared", 32'(bus_stat), 32'h0);
        check("R5 gap 1", 32'(irq_n), 32'h1);
        tick();
        check("R5 gap 2", 32'(irq_n), 32'h1);
        tick();
        check("R5 gap 3", 32'(irq_n), 32'h1);
        tick();
        check("R4 promoted", 32'(bus_stat), 32'h0024);
        check("R5 reassert", 32'(irq_n), 32'h0);
        bus_rd = 1'b1; tick(); bus_rd = 1'b0;
        tick(); tick(); tick(); tick();
        check("R5 empty promote", 32'(bus_stat), 32'h0);
        check("R5 idle irq_n", 32'(irq_n), 32'h1);
    endtask

    task automatic test_masked();
        do_reset();
        bus_en = 16'hFFF7;
        fire_bus(16'h0008);
        check("R6 status set", 32'(bus_stat), 32'h0008);
        check("R6 no irq", 32'(irq_n), 32'h1);
        fire_bus(16'h0002);
        check("R7 direct post", 32'(bus_stat), 32'h000A);
        check("R7 irq", 32'(irq_n), 32'h0);
    endtask

    task automatic test_merge();
        do_reset();
        bus_ev = 16'h0011; dma_ev = 8'h02;
        tick();
        bus_ev = '0; dma_ev = '0;
        check("R8 bus merge", 32'(bus_stat), 32'h0011);
        check("R8 dma merge", 32'(dma_stat), 32'h02);
        bus_rd = 1'b1; tick(); bus_rd = 1'b0;
        check("R11 gap masks dma pend", 32'(irq_n), 32'h1);
        tick(); tick(); tick();
        check("R8 nothing stacked", 32'(bus_stat), 32'h0);
        check("R11 dma still pending", 32'(irq_n), 32'h0);
    endtask

    task automatic test_fatal();
        do_reset();
        bus_en = 16'h0000; bus_fatal = 16'h0040;
        fire_bus(16'h0040);
        check("R9 status", 32'(bus_stat), 32'h0040);
        check("R9 irq", 32'(irq_n), 32'h0);
    endtask

    task automatic test_lock();
        do_reset();
        dma_fifo_empty = 1'b0;
        fire_dma(8'h01);
        fire_bus(16'h0004);
        tick(); tick();
        check("R10 held off", 32'(bus_stat), 32'h0);
        dma_fifo_empty = 1'b1;
        tick();
        check("R10 not yet", 32'(bus_stat), 32'h0);
        tick();
        check("R10 released", 32'(bus_stat), 32'h0004);
    endtask

    initial begin
        test_reset();
        test_basic();
        test_stack();
        test_masked();
        test_merge();
        test_fatal();
        test_lock();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule